// File: doc/BRIEF.md
# Command Response Buffer Register Responder

This block is the device-side register file of a memory-mapped command/response buffer interface for a security coprocessor. A host issues 32-bit reads and writes over a small request/response bus. The block decodes them into a locality handshake, a pair of power-state requests (make ready, go idle), a start doorbell, a cancel doorbell and a status word carrying an error flag and an idle flag. It also reports the fixed command and response buffer addresses and sizes.

The host sets request bits and the device acknowledges each one by clearing the bit itself. Locality ownership reads back as a two-bit pattern: a valid flag that is always set and an assigned flag that follows the host's requests. A stub engine stands in for command execution. It clears the start bit after a number of cycles taken from an input pin, or earlier if a cancel arrives.

Bus rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, returns exactly one response beat. Only one response may be outstanding, so `req_ready` is low while `rsp_valid` is high. A response stays valid with unchanged data until `rsp_ready` is seen high at a clock edge. Register offsets are byte addresses and only word-aligned offsets decode.

Top module: `crb_responder`

## Requirements
- R1: A request accepted at edge T raises `rsp_valid` after T with the read data sampled from the state before T (zero for writes). `req_ready` equals the inverse of `rsp_valid`. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold.
- R2: Locality state (offset 0x00) reads 0x80 out of reset. Writing bit 0 of locality control (0x08) makes it read 0x82 (bit 1 assigned, bit 7 valid). Writing bit 1 returns it to 0x80, and bit 1 wins when both are set. Bit 0 of locality status (0x0C) mirrors the assigned flag.
- R3: Writing a nonzero value to bits 1:0 of the request register (0x40) ORs them into the register. Bit 0 asks for ready and bit 1 asks for idle. The pending bits all clear together ACK_LAT cycles after the write that found the register empty.
- R4: Bit 1 of status (0x44) is the idle flag and is 1 out of reset. When the pending bits clear, idle becomes 0 if bit 0 was pending; otherwise idle becomes 1.
- R5: Writing 1 to bit 0 of start (0x4C) sets it when the locality is assigned, the device is not idle, no error is latched and start is clear. The bit self-clears max(1, `exec_latency`) cycles after the write.
- R6: Start and cancel writes have no effect while the locality is not assigned or the device is idle.
- R7: Bit 0 of cancel (0x48) takes the written bit. Writing 1 clears a running start bit on the same edge. Writing 0 clears the cancel bit.
- R8: A high `fault` sets bit 0 of status. The bit stays set until reset, and start writes have no effect while it is set.
- R9: Fixed fields read as parameters: interface ID at 0x30/0x34, command size 0x58, command address 0x5C/0x60, response size 0x64 and response address 0x68/0x6C. When the two addresses are equal, the response size reads as the command size.
- R10: Writes to read-only or reserved offsets have no effect. Reads of reserved or unaligned offsets, of 0x38/0x3C and of 0x50/0x54 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_rdata | output | 32 | Read data, zero for writes |
| fault | input | 1 | Raises the sticky error flag |
| exec_latency | input | LAT_W | Stub execution time in cycles |

## Verification
The bench sets ACK_LAT to 3. At that value a read issued two cycles after a request write still sees the bit pending, and a read two cycles later sees it cleared. It places the command and response buffers at the same address but gives RSP_SIZE a different value, so the size substitution in R9 becomes observable. Through `exec_latency` it sweeps the engine from zero (the one-cycle floor) to a long run that a cancel can cut short. A behavioural model runs beside the design and compares the response channel on every cycle. Back-pressure is exercised by holding `rsp_ready` low.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef logic [4:0] word_t;

  // word indices (byte offset / 4)
  localparam word_t W_LOC_STATE = 5'd0;
  localparam word_t W_LOC_CTRL  = 5'd2;
  localparam word_t W_LOC_STS   = 5'd3;
  localparam word_t W_ID_LO     = 5'd12;
  localparam word_t W_ID_HI     = 5'd13;
  localparam word_t W_REQ       = 5'd16;
  localparam word_t W_STATUS    = 5'd17;
  localparam word_t W_CANCEL    = 5'd18;
  localparam word_t W_START     = 5'd19;
  localparam word_t W_CMD_SIZE  = 5'd22;
  localparam word_t W_CMD_LO    = 5'd23;
  localparam word_t W_CMD_HI    = 5'd24;
  localparam word_t W_RSP_SIZE  = 5'd25;
  localparam word_t W_RSP_LO    = 5'd26;
  localparam word_t W_RSP_HI    = 5'd27;

  localparam int BIT_ASSIGNED = 1;
  localparam int BIT_VALID    = 7;
  localparam int BIT_ERR      = 0;
  localparam int BIT_IDLE     = 1;
endpackage

// File: rtl/crb_locality.sv
module crb_locality (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  output logic       assigned
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) assigned <= 1'b0;
    else if (ctrl_wr) begin
      if (ctrl_bits[1])      assigned <= 1'b0;
      else if (ctrl_bits[0]) assigned <= 1'b1;
    end
  end

  // R2: relinquish wins and clears ownership
  a_r2_relinquish: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[1]) |=> !assigned);
  // R2: request grants ownership
  a_r2_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[0] && !ctrl_bits[1]) |=> assigned);
  // R2: ownership moves only on a control write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(assigned));
endmodule

// File: rtl/crb_power.sv
module crb_power #(
  parameter int ACK_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [1:0] req_bits,
  output logic [1:0] pend,
  output logic       idle
);
  localparam int CW = $clog2(ACK_LAT + 2);
  logic [CW-1:0] cnt;
  logic          new_req;

  assign new_req = req_wr && (req_bits != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'b00;
      cnt  <= '0;
      idle <= 1'b1;
    end else if (new_req) begin
      pend <= pend | req_bits;
      if (pend == 2'b00) cnt <= CW'(ACK_LAT);
    end else if (pend != 2'b00) begin
      if (cnt <= CW'(1)) begin
        pend <= 2'b00;
        idle <= !pend[0];
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R3: pending bits only clear as a whole, never change otherwise
  a_r3_clear_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != 2'b00 && !new_req) |=> (pend == 2'b00 || pend == $past(pend)));
  // R4: completed ready request leaves the device active
  a_r4_ready_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[0]) |-> !idle);
  // R4: completed idle-only request sets idle
  a_r4_idle_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pend[1]) && !$past(pend[0])) |-> idle);
endmodule

// File: rtl/crb_exec.sv
module crb_exec #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             err,
  input  logic             start_wr,
  input  logic             cancel_wr,
  input  logic             wbit,
  input  logic [LAT_W-1:0] lat,
  output logic             start,
  output logic             cancel
);
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start  <= 1'b0;
      cancel <= 1'b0;
      cnt    <= '0;
    end else if (cancel_wr && gate) begin
      cancel <= wbit;
      if (wbit) start <= 1'b0;
    end else if (start_wr && wbit && gate && !start && !err) begin
      start <= 1'b1;
      cnt   <= (lat == '0) ? LAT_W'(1) : lat;
    end else if (start) begin
      if (cnt <= LAT_W'(1)) start <= 1'b0;
      else                  cnt   <= cnt - LAT_W'(1);
    end
  end

  // R5, R6, R8: a launch only happens when allowed
  a_r6_launch_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(gate && !err && start_wr));
  // R7: an accepted cancel stops execution
  a_r7_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_wr && gate && wbit) |=> !start);
  // R6: cancel changes only under the gate
  a_r6_cancel_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cancel) |-> $past(gate && cancel_wr));
endmodule

// File: rtl/crb_responder.sv
module crb_responder
  import crb_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          LAT_W    = 8,
  parameter int          ACK_LAT  = 4,
  parameter logic [63:0] IF_ID    = 64'h0000_0000_1A2B_0F41,
  parameter logic [63:0] CMD_ADDR = 64'h0000_0000_FED4_0080,
  parameter logic [31:0] CMD_SIZE = 32'h0000_0F80,
  parameter logic [63:0] RSP_ADDR = 64'h0000_0000_FED4_0080,
  parameter logic [31:0] RSP_SIZE = 32'h0000_0F80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              fault,
  input  logic [LAT_W-1:0]  exec_latency
);
  localparam logic [31:0] EFF_RSP_SIZE = (CMD_ADDR == RSP_ADDR) ? CMD_SIZE : RSP_SIZE;

  logic        fire, hit, wr;
  word_t       widx;
  logic        assigned, idle, start, cancel, err_q;
  logic [1:0]  pend;
  logic [31:0] rd;
  logic        unused_bits;

  assign req_ready   = !rsp_valid;
  assign fire        = req_valid && req_ready;
  assign widx        = req_addr[6:2];
  assign hit         = ((req_addr >> 7) == '0) && (req_addr[1:0] == 2'b00);
  assign wr          = fire && req_write && hit;
  assign unused_bits = ^req_wdata[31:2];

  crb_locality u_loc (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr && widx == W_LOC_CTRL),
    .ctrl_bits(req_wdata[1:0]),
    .assigned(assigned)
  );

  crb_power #(.ACK_LAT(ACK_LAT)) u_pwr (
    .clk(clk), .rst_n(rst_n),
    .req_wr(wr && widx == W_REQ),
    .req_bits(req_wdata[1:0]),
    .pend(pend), .idle(idle)
  );

  crb_exec #(.LAT_W(LAT_W)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .gate(assigned && !idle),
    .err(err_q),
    .start_wr(wr && widx == W_START),
    .cancel_wr(wr && widx == W_CANCEL),
    .wbit(req_wdata[0]),
    .lat(exec_latency),
    .start(start), .cancel(cancel)
  );

  always_comb begin
    rd = 32'h0;
    if (hit && !req_write) begin
      case (widx)
        W_LOC_STATE: begin
          rd[BIT_VALID]    = 1'b1;
          rd[BIT_ASSIGNED] = assigned;
        end
        W_LOC_STS:  rd[0] = assigned;
        W_ID_LO:    rd = IF_ID[31:0];
        W_ID_HI:    rd = IF_ID[63:32];
        W_REQ:      rd[1:0] = pend;
        W_STATUS: begin
          rd[BIT_ERR]  = err_q;
          rd[BIT_IDLE] = idle;
        end
        W_CANCEL:   rd[0] = cancel;
        W_START:    rd[0] = start;
        W_CMD_SIZE: rd = CMD_SIZE;
        W_CMD_LO:   rd = CMD_ADDR[31:0];
        W_CMD_HI:   rd = CMD_ADDR[63:32];
        W_RSP_SIZE: rd = EFF_RSP_SIZE;
        W_RSP_LO:   rd = RSP_ADDR[31:0];
        W_RSP_HI:   rd = RSP_ADDR[63:32];
        default:    rd = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
      err_q     <= 1'b0;
    end else begin
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (fault) err_q <= 1'b1;
    end
  end

  // R1: a stalled response holds its data
  a_r1_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R8: the error flag is sticky
  a_r8_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: tb/tb_crb_responder.sv
module tb_crb_responder;
  localparam logic [63:0] IFID  = 64'h0000_0001_1A2B_0F41;
  localparam logic [63:0] CADDR = 64'h0000_0002_FED4_0080;
  localparam logic [31:0] CSIZE = 32'h0000_0F80;
  localparam logic [31:0] RSIZE = 32'h0000_0100;
  localparam int          ACK   = 3;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1, fault = 0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  exec_latency = 8'd6;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  crb_responder #(.ADDR_W(7), .LAT_W(8), .ACK_LAT(ACK), .IF_ID(IFID),
    .CMD_ADDR(CADDR), .CMD_SIZE(CSIZE), .RSP_ADDR(CADDR), .RSP_SIZE(RSIZE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .fault(fault), .exec_latency(exec_latency));

  // behavioural reference model
  bit m_asg, m_idle, m_start, m_cancel, m_err, m_rv;
  int m_pend, m_pcnt, m_ecnt;
  logic [31:0] m_rd;

  function automatic logic [31:0] mread(int w);
    case (w)
      0:  return 32'h80 | (32'(m_asg) << 1);
      3:  return 32'(m_asg);
      12: return IFID[31:0];
      13: return IFID[63:32];
      16: return 32'(m_pend);
      17: return (32'(m_idle) << 1) | 32'(m_err);
      18: return 32'(m_cancel);
      19: return 32'(m_start);
      22: return CSIZE;
      23: return CADDR[31:0];
      24: return CADDR[63:32];
      25: return CSIZE;   // shared buffer: response size equals command size
      26: return CADDR[31:0];
      27: return CADDR[63:32];
      default: return 32'h0;
    endcase
  endfunction

  bit n_asg, n_idle, n_start, n_cancel, n_err, n_rv, fire, hit, wr, gate;
  int n_pend, n_pcnt, n_ecnt, w;
  logic [31:0] n_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_asg = 0; m_idle = 1; m_start = 0; m_cancel = 0; m_err = 0; m_rv = 0;
      m_pend = 0; m_pcnt = 0; m_ecnt = 0; m_rd = 0;
    end else begin
      n_asg = m_asg; n_idle = m_idle; n_start = m_start; n_cancel = m_cancel;
      n_err = m_err; n_rv = m_rv; n_pend = m_pend; n_pcnt = m_pcnt;
      n_ecnt = m_ecnt; n_rd = m_rd;
      fire = req_valid && !m_rv;
      hit  = (req_addr[1:0] == 2'b00);
      w    = int'(req_addr) / 4;
      wr   = fire && req_write && hit;
      gate = m_asg && !m_idle;
      if (fire) begin n_rv = 1; n_rd = (hit && !req_write) ? mread(w) : 32'h0; end
      else if (m_rv && rsp_ready) n_rv = 0;
      if (fault) n_err = 1;
      if (wr && w == 2) begin
        if (req_wdata[1]) n_asg = 0; else if (req_wdata[0]) n_asg = 1;
      end
      if (wr && w == 16 && req_wdata[1:0] != 0) begin
        n_pend = m_pend | int'(req_wdata[1:0]);
        if (m_pend == 0) n_pcnt = ACK;
      end else if (m_pend != 0) begin
        if (m_pcnt <= 1) begin n_pend = 0; n_idle = !m_pend[0]; end
        else n_pcnt = m_pcnt - 1;
      end
      if (wr && w == 18 && gate) begin
        n_cancel = req_wdata[0];
        if (req_wdata[0]) n_start = 0;
      end else if (wr && w == 19 && req_wdata[0] && gate && !m_start && !m_err) begin
        n_start = 1; n_ecnt = (exec_latency == 0) ? 1 : int'(exec_latency);
      end else if (m_start) begin
        if (m_ecnt <= 1) n_start = 0; else n_ecnt = m_ecnt - 1;
      end
      m_asg = n_asg; m_idle = n_idle; m_start = n_start; m_cancel = n_cancel;
      m_err = n_err; m_rv = n_rv; m_pend = n_pend; m_pcnt = n_pcnt;
      m_ecnt = n_ecnt; m_rd = n_rd;
    end
  end

  // R1: cycle-by-cycle comparison of the response channel
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (rsp_valid !== m_rv || req_ready !== !m_rv || (m_rv && rsp_rdata !== m_rd)) begin
      errors++;
      $display("FAIL R1 model: valid=%0b ready=%0b data=%h expected valid=%0b data=%h",
               rsp_valid, req_ready, rsp_rdata, m_rv, m_rd);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr_i, input logic [6:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    req_valid = 1; req_write = wr_i; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    q = rsp_rdata;
  endtask

  task automatic wrr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] q;
    acc(1'b1, a, d, q);
  endtask

  task automatic rdc(input logic [6:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] q;
    acc(1'b0, a, 32'h0, q);
    chk(tag, q, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // reset state
    rdc(7'h00, 32'h80, "R2 reset locality");
    rdc(7'h44, 32'h2,  "R4 reset idle");
    rdc(7'h40, 32'h0,  "R3 reset request");
    // locality request
    wrr(7'h08, 32'h1);
    rdc(7'h00, 32'h82, "R2 assigned");
    rdc(7'h0C, 32'h1,  "R2 locality status");
    // start while idle ignored
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h0, "R6 start while idle");
    // command ready handshake
    wrr(7'h40, 32'h1);
    rdc(7'h40, 32'h1, "R3 request pending");
    rdc(7'h40, 32'h0, "R3 request acknowledged");
    rdc(7'h44, 32'h0, "R4 ready clears idle");
    // execution
    wrr(7'h48, 32'h0);
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h1, "R5 start running");
    repeat (8) @(posedge clk);
    rdc(7'h4C, 32'h0, "R5 start completed");
    exec_latency = 8'd0;
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h0, "R5 zero latency floor");
    // cancel
    exec_latency = 8'd40;
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h1, "R5 long run");
    wrr(7'h48, 32'h1);
    rdc(7'h4C, 32'h0, "R7 cancel stops start");
    rdc(7'h48, 32'h1, "R7 cancel pending");
    wrr(7'h48, 32'h0);
    rdc(7'h48, 32'h0, "R7 cancel cleared");
    // relinquish and gating
    wrr(7'h08, 32'h2);
    rdc(7'h00, 32'h80, "R2 relinquished");
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h0, "R6 start without locality");
    wrr(7'h48, 32'h1);
    rdc(7'h48, 32'h0, "R6 cancel without locality");
    wrr(7'h08, 32'h3);
    rdc(7'h00, 32'h80, "R2 relinquish wins");
    // go idle
    wrr(7'h08, 32'h1);
    wrr(7'h40, 32'h2);
    repeat (4) @(posedge clk);
    rdc(7'h44, 32'h2, "R4 go idle sets idle");
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h0, "R6 start while idle");
    wrr(7'h40, 32'h3);
    repeat (4) @(posedge clk);
    rdc(7'h44, 32'h0, "R4 both requests leave active");
    rdc(7'h40, 32'h0, "R3 both bits cleared");
    // fixed fields
    rdc(7'h30, IFID[31:0],  "R9 id low");
    rdc(7'h34, IFID[63:32], "R9 id high");
    rdc(7'h58, CSIZE,        "R9 command size");
    rdc(7'h5C, CADDR[31:0],  "R9 command address low");
    rdc(7'h60, CADDR[63:32], "R9 command address high");
    rdc(7'h64, CSIZE,        "R9 shared response size");
    rdc(7'h68, CADDR[31:0],  "R9 response address low");
    rdc(7'h6C, CADDR[63:32], "R9 response address high");
    // read-only and reserved
    wrr(7'h58, 32'hFFFF);
    rdc(7'h58, CSIZE, "R10 read-only size");
    wrr(7'h04, 32'hFF);
    rdc(7'h04, 32'h0, "R10 reserved write");
    rdc(7'h70, 32'h0, "R10 reserved read");
    rdc(7'h41, 32'h0, "R10 unaligned read");
    rdc(7'h38, 32'h0, "R10 extension zero");
    wrr(7'h00, 32'h0);
    rdc(7'h00, 32'h82, "R10 locality state read-only");
    wrr(7'h50, 32'h1);
    rdc(7'h50, 32'h0, "R10 interrupt enable zero");
    // back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 7'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    held = rsp_rdata;
    chk("R1 response valid", 32'(rsp_valid), 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 stalled valid", 32'(rsp_valid), 32'h1);
      chk("R1 stalled ready", 32'(req_ready), 32'h0);
      chk("R1 stalled data", rsp_rdata, held);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R1 response released", 32'(rsp_valid), 32'h0);
    // error
    exec_latency = 8'd6;
    @(negedge clk);
    fault = 1;
    @(negedge clk);
    fault = 0;
    rdc(7'h44, 32'h1, "R8 error latched");
    wrr(7'h4C, 32'h1);
    rdc(7'h4C, 32'h0, "R8 start blocked by error");
    rdc(7'h44, 32'h1, "R8 error sticky");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule